// File: doc/BRIEF.md
# Variable-Width Saturating Clip Unit

This block is the closing stage of a fixed-point datapath. It takes a 32-bit intermediate result and clamps it into a range chosen for each operation. The range comes from a bit count and a signed or unsigned selection. A signed count of n gives a range from -2^(n-1) to 2^(n-1)-1. An unsigned count of n gives a range from 0 to 2^n-1. The clipped value is returned sign-extended or zero-extended to 32 bits. A flag reports that clamping took place. The result appears one clock after the operation is presented.

The bit count is taken either from an immediate field carried with the operation or from the low bits of a runtime register operand, so that the same hardware serves fixed formats (such as 16-bit signed or unsigned samples) and data-dependent widths. Counts outside the legal range are normalised rather than rejected. In unsigned mode the input is read as a two's complement number, so a negative value always clips to zero.

Top module: `satclip_unit`

## Requirements
- R1: An operation presented with `in_valid` high at a rising clock edge produces `out_valid` high, together with its result, directly after that edge. `out_valid` is low after any edge at which `in_valid` was low.
- R2: In signed mode (`in_unsigned`=0) with an effective count n, the input read as signed is clamped to [-2^(n-1), 2^(n-1)-1]. With n=12 this is -2048..2047.
- R3: In unsigned mode (`in_unsigned`=1), a non-negative input is clamped to [0, 2^n-1]. With n=10 this is 0..1023.
- R4: In unsigned mode, any input with bit 31 set (negative) yields 0.
- R5: With `cnt_src`=0 the count is `cnt_imm`. With `cnt_src`=1 the count is bits [5:0] of `cnt_opnd`, and `cnt_imm` has no effect.
- R6: A count of 0 is treated as 1, and a count of 33..63 is treated as 32.
- R7: In signed mode, a count of 32 returns every input unchanged with `out_sat`=0.
- R8: `out_sat` is 1 exactly when `out_value` differs from the input of the same operation.
- R9: While `in_valid` is low, `out_value` and `out_sat` keep the values of the last operation.
- R10: After reset, `out_valid`, `out_value` and `out_sat` are all 0.
- R11: The 16-bit cases give -32768..32767 (signed) and 0..65535 (unsigned).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_value | input | 32 | Value to clip, two's complement |
| in_unsigned | input | 1 | 1 = unsigned range, 0 = signed range |
| cnt_src | input | 1 | Count source: 0 = immediate, 1 = register operand |
| cnt_imm | input | 6 | Immediate bit count |
| cnt_opnd | input | 32 | Register operand; bits [5:0] hold the count |
| out_valid | output | 1 | Result valid |
| out_value | output | 32 | Clipped value, extended to 32 bits |
| out_sat | output | 1 | Clamping occurred |

## Verification
The properties compare each registered result with the inputs sampled one edge earlier. They therefore assume that the inputs are stable around the rising edge and that `in_valid` is held low throughout reset. The bench changes every input only on the falling edge and keeps `in_valid` low until reset has been released. The pass-through property is checked only for an immediate count of exactly 32. The bench drives the count operand with upper bits set, which confirms that those bits do not affect the result.

// File: rtl/satclip_pkg.sv
package satclip_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = 6;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic {
        SRC_IMM = 1'b0,
        SRC_REG = 1'b1
    } cnt_src_e;

    typedef struct packed {
        logic  vld;
        word_t res;
        logic  sat;
    } stage_t;

endpackage

// File: rtl/satclip_count_sel.sv
module satclip_count_sel
    import satclip_pkg::*;
#(
    parameter int unsigned DATA_W = satclip_pkg::DATA_W,
    parameter int unsigned CNT_W  = satclip_pkg::CNT_W
) (
    input  cnt_src_e          src,
    input  logic [CNT_W-1:0]  imm,
    input  logic [DATA_W-1:0] opnd,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(1);

    logic [CNT_W-1:0] raw;

    always_comb begin
        raw = (src == SRC_REG) ? opnd[CNT_W-1:0] : imm;
        if (raw == '0) begin
            cnt = MIN_CNT;
        end else if (raw > MAX_CNT) begin
            cnt = MAX_CNT;
        end else begin
            cnt = raw;
        end
    end

    always_comb begin
        assert (cnt >= MIN_CNT && cnt <= MAX_CNT); // R6
    end

endmodule

// File: rtl/satclip_bounds.sv
module satclip_bounds #(
    parameter int unsigned DATA_W = satclip_pkg::DATA_W,
    parameter int unsigned CNT_W  = satclip_pkg::CNT_W
) (
    input  logic [CNT_W-1:0]  cnt,
    input  logic              is_uns,
    output logic [DATA_W-1:0] hi,
    output logic [DATA_W-1:0] lo
);
    logic [DATA_W:0]   pow;
    logic [DATA_W-1:0] mask;

    always_comb begin
        pow  = (DATA_W+1)'(1) << cnt;
        mask = pow[DATA_W-1:0] - DATA_W'(1);
        if (is_uns) begin
            hi = mask;
            lo = '0;
        end else begin
            hi = mask >> 1;
            lo = ~(mask >> 1);
        end
    end

endmodule

// File: rtl/satclip_core.sv
module satclip_core #(
    parameter int unsigned DATA_W = satclip_pkg::DATA_W
) (
    input  logic [DATA_W-1:0] value,
    input  logic              is_uns,
    input  logic [DATA_W-1:0] hi,
    input  logic [DATA_W-1:0] lo,
    output logic [DATA_W-1:0] res,
    output logic              sat
);
    always_comb begin
        res = value;
        sat = 1'b0;
        if (is_uns) begin
            if (value[DATA_W-1]) begin
                res = '0;
                sat = 1'b1;
            end else if (value > hi) begin
                res = hi;
                sat = 1'b1;
            end
        end else begin
            if ($signed(value) > $signed(hi)) begin
                res = hi;
                sat = 1'b1;
            end else if ($signed(value) < $signed(lo)) begin
                res = lo;
                sat = 1'b1;
            end
        end
    end

endmodule

// File: rtl/satclip_unit.sv
module satclip_unit
    import satclip_pkg::*;
#(
    parameter int unsigned DATA_W = satclip_pkg::DATA_W,
    parameter int unsigned CNT_W  = satclip_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_value,
    input  logic              in_unsigned,
    input  logic              cnt_src,
    input  logic [CNT_W-1:0]  cnt_imm,
    input  logic [DATA_W-1:0] cnt_opnd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_value,
    output logic              out_sat
);
    logic [CNT_W-1:0]  cnt_eff;
    logic [DATA_W-1:0] bnd_hi;
    logic [DATA_W-1:0] bnd_lo;
    logic [DATA_W-1:0] clip_res;
    logic              clip_sat;

    stage_t stage_d;
    stage_t stage_q;

    satclip_count_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
        .src  (cnt_src_e'(cnt_src)),
        .imm  (cnt_imm),
        .opnd (cnt_opnd),
        .cnt  (cnt_eff)
    );

    satclip_bounds #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bnd (
        .cnt    (cnt_eff),
        .is_uns (in_unsigned),
        .hi     (bnd_hi),
        .lo     (bnd_lo)
    );

    satclip_core #(.DATA_W(DATA_W)) u_core (
        .value  (in_value),
        .is_uns (in_unsigned),
        .hi     (bnd_hi),
        .lo     (bnd_lo),
        .res    (clip_res),
        .sat    (clip_sat)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            stage_d.res = clip_res;
            stage_d.sat = clip_sat;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.vld;
    assign out_value = stage_q.res;
    assign out_sat   = stage_q.sat;

    AST_LATENCY_ON: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_LATENCY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_UNS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_unsigned) |=> !out_value[DATA_W-1]); // R4
    AST_FLAG_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sat == (out_value != $past(in_value)))); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_value) && $stable(out_sat))); // R9
    AST_PASS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_unsigned && !cnt_src && cnt_imm == CNT_W'(DATA_W))
        |=> (out_value == $past(in_value))); // R7

endmodule

// File: tb/satclip_unit_tb.sv
module satclip_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic        in_unsigned = 1'b0;
    logic        cnt_src = 1'b0;
    logic [5:0]  cnt_imm = '0;
    logic [31:0] cnt_opnd = '0;
    logic        out_valid;
    logic [31:0] out_value;
    logic        out_sat;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    satclip_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_unsigned(in_unsigned), .cnt_src(cnt_src), .cnt_imm(cnt_imm),
        .cnt_opnd(cnt_opnd), .out_valid(out_valid), .out_value(out_value),
        .out_sat(out_sat)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, result sampled at the next falling edge.
    task automatic run_op(input string req, input logic [31:0] v, input logic uns,
                          input logic src, input logic [5:0] imm, input logic [31:0] opnd,
                          input logic [31:0] exp_v, input logic exp_s);
        @(negedge clk);
        in_valid = 1'b1; in_value = v; in_unsigned = uns;
        cnt_src = src; cnt_imm = imm; cnt_opnd = opnd;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R1 valid"}, 32'(out_valid), 32'd1);
        check({req, " value"}, out_value, exp_v);
        check({req, " R8 flag"}, 32'(out_sat), 32'(exp_s));
    endtask

    task automatic t_reset();
        check("R10 valid", 32'(out_valid), 32'd0);
        check("R10 value", out_value, 32'd0);
        check("R10 flag", 32'(out_sat), 32'd0);
    endtask

    task automatic t_signed12();
        run_op("R2 s12 over",  32'd5000,      1'b0, 1'b0, 6'd12, '0, 32'd2047,       1'b1);
        run_op("R2 s12 under", -32'sd5000,    1'b0, 1'b0, 6'd12, '0, 32'hFFFFF800,   1'b1);
        run_op("R2 s12 in",    32'd100,       1'b0, 1'b0, 6'd12, '0, 32'd100,        1'b0);
        run_op("R2 s12 top",   32'd2047,      1'b0, 1'b0, 6'd12, '0, 32'd2047,       1'b0);
        run_op("R2 s12 bot",   32'hFFFFF800,  1'b0, 1'b0, 6'd12, '0, 32'hFFFFF800,   1'b0);
        run_op("R2 s12 top+1", 32'd2048,      1'b0, 1'b0, 6'd12, '0, 32'd2047,       1'b1);
    endtask

    task automatic t_unsigned10();
        run_op("R3 u10 top",   32'd1023,      1'b1, 1'b0, 6'd10, '0, 32'd1023, 1'b0);
        run_op("R3 u10 top+1", 32'd1024,      1'b1, 1'b0, 6'd10, '0, 32'd1023, 1'b1);
        run_op("R3 u10 in",    32'd500,       1'b1, 1'b0, 6'd10, '0, 32'd500,  1'b0);
        run_op("R4 u10 neg1",  32'hFFFFFFFF,  1'b1, 1'b0, 6'd10, '0, 32'd0,    1'b1);
        run_op("R4 u10 min",   32'h80000000,  1'b1, 1'b0, 6'd10, '0, 32'd0,    1'b1);
    endtask

    task automatic t_sixteen();
        run_op("R11 s16 over",  32'd40000,    1'b0, 1'b0, 6'd16, '0, 32'd32767,      1'b1);
        run_op("R11 s16 under", -32'sd40000,  1'b0, 1'b0, 6'd16, '0, 32'hFFFF8000,   1'b1);
        run_op("R11 u16 over",  32'd70000,    1'b1, 1'b0, 6'd16, '0, 32'd65535,      1'b1);
        run_op("R11 u16 in",    32'd65535,    1'b1, 1'b0, 6'd16, '0, 32'd65535,      1'b0);
    endtask

    task automatic t_source();
        // Register count 8 in low bits; immediate 32 must have no effect.
        run_op("R5 reg s8",  32'd300, 1'b0, 1'b1, 6'd32, 32'hFFFFFF08, 32'd127, 1'b1);
        run_op("R5 reg u4",  32'd300, 1'b1, 1'b1, 6'd1,  32'h00000104, 32'd15,  1'b1);
        run_op("R5 imm s8",  32'd300, 1'b0, 1'b0, 6'd8,  32'h00000020, 32'd127, 1'b1);
    endtask

    task automatic t_normalise();
        run_op("R6 zero s pos", 32'd5,         1'b0, 1'b0, 6'd0,  '0, 32'd0,         1'b1);
        run_op("R6 zero s neg", -32'sd5,       1'b0, 1'b0, 6'd0,  '0, 32'hFFFFFFFF,  1'b1);
        run_op("R6 zero u",     32'd5,         1'b1, 1'b0, 6'd0,  '0, 32'd1,         1'b1);
        run_op("R6 imm40",      32'h7FFFFFFF,  1'b0, 1'b0, 6'd40, '0, 32'h7FFFFFFF,  1'b0);
        run_op("R6 reg63",      32'h80000000,  1'b0, 1'b1, 6'd1,  32'h0000003F, 32'h80000000, 1'b0);
    endtask

    task automatic t_full();
        run_op("R7 s32 min", 32'h80000000, 1'b0, 1'b0, 6'd32, '0, 32'h80000000, 1'b0);
        run_op("R7 s32 max", 32'h7FFFFFFF, 1'b0, 1'b0, 6'd32, '0, 32'h7FFFFFFF, 1'b0);
        run_op("R3 u32 max", 32'h7FFFFFFF, 1'b1, 1'b0, 6'd32, '0, 32'h7FFFFFFF, 1'b0);
    endtask

    task automatic t_hold();
        run_op("R9 setup", 32'd9999, 1'b0, 1'b0, 6'd12, '0, 32'd2047, 1'b1);
        @(negedge clk);
        in_value = 32'd3; in_unsigned = 1'b1; cnt_imm = 6'd2;
        @(negedge clk);
        check("R9 valid low", 32'(out_valid), 32'd0);
        check("R9 value held", out_value, 32'd2047);
        check("R9 flag held", 32'(out_sat), 32'd1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_signed12();
        t_unsigned10();
        t_sixteen();
        t_source();
        t_normalise();
        t_full();
        t_hold();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule